// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block carries out byte-wise block operations on memory for a processor datapath. A start strobe hands it a source pointer, a destination pointer, a 16-bit byte counter, an accumulator byte, the current flag byte and three mode bits. In copy mode it moves bytes from the source address to the destination address. In compare mode it compares the accumulator with the byte at the source address, without writing anything back to memory. After every byte it steps the pointers up or down and counts the counter down.

In single mode one byte is processed. In repeat mode the sequencer keeps going by itself until the counter reaches zero. In compare mode it also stops at the first byte equal to the accumulator. The updated pointers, counter and flags appear on registered outputs. A one-cycle done pulse marks the end of the operation.

The block runs on one clock and keeps a fixed cycle budget for each byte. That budget is longer when another iteration follows, so the timing matches the processor it serves. Memory is reached through a byte-wide port with a synchronous read.

Top module: `blk_xfer_seq`

## Requirements
- R1: Copy (mode_cmp=0): the byte read at src_ptr is written to dst_ptr, then both pointers step by +1 (mode_dec=0) or -1 (mode_dec=1) and the counter drops by one.
- R2: Compare (mode_cmp=1): memory is never written, src_ptr steps by +1 or -1, dst_ptr is unchanged, the counter drops by one, the subtract flag (bit 1) is set and the carry flag (bit 0) is kept.
- R3: Flag byte layout is sign bit 7, zero bit 6, half bit 4, count-status bit 2, subtract bit 1 and carry bit 0. In compare, for acc minus the byte, sign is bit 7 of the difference, zero means the two are equal, and half is a borrow out of the low nibble. In copy, half and subtract are cleared and sign, zero and carry are kept. Bits 5 and 3 are always kept.
- R4: After every byte, count-status (bit 2) is 1 when the updated counter is nonzero and 0 when it is zero.
- R5: Repeat copy (mode_rep=1) goes on until the counter reaches zero, so it ends with counter 0 and count-status 0.
- R6: Repeat compare ends after the first byte equal to acc, or when the counter reaches zero, whichever comes first.
- R7: done is high for exactly one cycle. If the start strobe is sampled at edge 0, done rises at edge 16 for a single byte. Each iteration that is followed by another adds 21 edges.
- R8: The counter is decremented before it is tested, so a start value of 0 becomes 0xFFFF and count-status is set.
- R9: A start strobe while busy is high is ignored, together with its data inputs.
- R10: Memory port: mem_rd high for one cycle with mem_addr returns mem_rdata on the next cycle. A write is mem_we with mem_addr and mem_wdata in the same cycle. Reads and writes never overlap, and there is no access while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| mode_cmp | input | 1 | 1 = compare, 0 = copy |
| mode_dec | input | 1 | 1 = pointers step down, 0 = step up |
| mode_rep | input | 1 | 1 = repeat, 0 = single byte |
| acc_in | input | 8 | Accumulator byte for compare |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte counter |
| flags_in | input | 8 | Initial flag byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_rd |
| src_ptr | output | 16 | Updated source pointer |
| dst_ptr | output | 16 | Updated destination pointer |
| cnt_out | output | 16 | Updated counter |
| flags_out | output | 8 | Updated flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The results are only valid once done rises. That happens 16 edges after the start edge, plus 21 for every iteration that repeats. Each expected item in the scoreboard carries its own due cycle, derived from the same per-iteration rule in a reference model. The monitor samples on falling edges and compares the arrival cycle of done with that due cycle, then compares the pointers, counter, flags and the whole memory image. A done with nothing expected is also counted as a failure. Extra start strobes sent mid-operation must leave both the result and its due cycle unchanged.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
  // Flag byte bit positions.
  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;
  localparam int FLG_W  = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/blk_step_timer.sv
module blk_step_timer #(
  parameter int STEP_CYC = 16,
  parameter int REP_CYC  = 21,
  parameter int PW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          long_step,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] SHORT_END = PW'(STEP_CYC - 1);
  localparam logic [PW-1:0] LONG_END  = PW'(REP_CYC - 1);

  assign last = active && (phase == (long_step ? LONG_END : SHORT_END));

  always_ff @(posedge clk) begin
    if (rst || !active || last) phase <= '0;
    else                        phase <= phase + PW'(1);
  end
endmodule

// File: rtl/blk_ptr_step.sv
module blk_ptr_step #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic          dec,
  input  logic          cmp,
  output logic [AW-1:0] src_nx,
  output logic [AW-1:0] dst_nx,
  output logic [CW-1:0] cnt_nx,
  output logic          cnt_nz
);
  logic [AW-1:0] dst_step;

  assign src_nx   = dec ? src - AW'(1) : src + AW'(1);
  assign dst_step = dec ? dst - AW'(1) : dst + AW'(1);
  assign dst_nx   = cmp ? dst : dst_step;
  // Decrement first, test afterwards: a zero count wraps to all ones.
  assign cnt_nx   = cnt - CW'(1);
  assign cnt_nz   = |cnt_nx;
endmodule

// File: rtl/blk_flag_unit.sv
module blk_flag_unit
  import blk_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [FLG_W-1:0] flg,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    data,
  input  logic             cmp,
  input  logic             rep,
  input  logic             cnt_nz,
  output logic [FLG_W-1:0] flg_nx,
  output logic             cont
);
  localparam int HW = DW / 2;

  logic [DW-1:0] diff;
  logic          half_borrow;
  logic          match;

  assign diff        = acc - data;
  assign half_borrow = acc[HW-1:0] < data[HW-1:0];
  assign match       = (acc == data);

  always_comb begin
    flg_nx         = flg;
    flg_nx[FLG_H]  = cmp & half_borrow;
    flg_nx[FLG_N]  = cmp;
    flg_nx[FLG_PV] = cnt_nz;
    if (cmp) begin
      flg_nx[FLG_S] = diff[DW-1];
      flg_nx[FLG_Z] = ~|diff;
    end
  end

  assign cont = rep & cnt_nz & ~(cmp & match);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int DW       = 8,
  parameter int STEP_CYC = 16,
  parameter int REP_CYC  = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_cmp,
  input  logic             mode_dec,
  input  logic             mode_rep,
  input  logic [DW-1:0]    acc_in,
  input  logic [AW-1:0]    src_in,
  input  logic [AW-1:0]    dst_in,
  input  logic [CW-1:0]    cnt_in,
  input  logic [FLG_W-1:0] flags_in,
  output logic             mem_rd,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    src_ptr,
  output logic [AW-1:0]    dst_ptr,
  output logic [CW-1:0]    cnt_out,
  output logic [FLG_W-1:0] flags_out,
  output logic             busy,
  output logic             done
);
  localparam int PW = $clog2(REP_CYC);
  localparam logic [PW-1:0] PH_READ = PW'(0);  // read strobe goes out
  localparam logic [PW-1:0] PH_DATA = PW'(2);  // read data present, write-back

  seq_state_e       state;
  logic [AW-1:0]    src_q, dst_q, src_nx, dst_nx;
  logic [CW-1:0]    cnt_q, cnt_nx;
  logic [DW-1:0]    acc_q;
  logic [FLG_W-1:0] flg_q, flg_nx;
  logic             cmp_q, dec_q, rep_q, cont_q, cont_nx, cnt_nz;
  logic [PW-1:0]    phase;
  logic             last, active;

  assign active = (state == ST_RUN);

  blk_step_timer #(.STEP_CYC(STEP_CYC), .REP_CYC(REP_CYC), .PW(PW)) u_timer (
    .clk(clk), .rst(rst), .active(active), .long_step(cont_q),
    .phase(phase), .last(last)
  );

  blk_ptr_step #(.AW(AW), .CW(CW)) u_ptr (
    .src(src_q), .dst(dst_q), .cnt(cnt_q), .dec(dec_q), .cmp(cmp_q),
    .src_nx(src_nx), .dst_nx(dst_nx), .cnt_nx(cnt_nx), .cnt_nz(cnt_nz)
  );

  blk_flag_unit #(.DW(DW)) u_flag (
    .flg(flg_q), .acc(acc_q), .data(mem_rdata), .cmp(cmp_q), .rep(rep_q),
    .cnt_nz(cnt_nz), .flg_nx(flg_nx), .cont(cont_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      acc_q     <= '0;
      flg_q     <= '0;
      cmp_q     <= 1'b0;
      dec_q     <= 1'b0;
      rep_q     <= 1'b0;
      cont_q    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      mem_we <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state  <= ST_RUN;
          src_q  <= src_in;
          dst_q  <= dst_in;
          cnt_q  <= cnt_in;
          acc_q  <= acc_in;
          flg_q  <= flags_in;
          cmp_q  <= mode_cmp;
          dec_q  <= mode_dec;
          rep_q  <= mode_rep;
          cont_q <= 1'b0;
        end
      end else begin
        if (phase == PH_READ) begin
          mem_rd   <= 1'b1;
          mem_addr <= src_q;
        end
        if (phase == PH_DATA) begin
          if (!cmp_q) begin
            mem_we    <= 1'b1;
            mem_addr  <= dst_q;
            mem_wdata <= mem_rdata;
          end
          src_q  <= src_nx;
          dst_q  <= dst_nx;
          cnt_q  <= cnt_nx;
          flg_q  <= flg_nx;
          cont_q <= cont_nx;
        end
        if (last && !cont_q) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign src_ptr   = src_q;
  assign dst_ptr   = dst_q;
  assign cnt_out   = cnt_q;
  assign flags_out = flg_q;
  assign busy      = active;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk
  import blk_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             mem_rd,
  input logic             mem_we,
  input logic [CW-1:0]    cnt_out,
  input logic [FLG_W-1:0] flags_out,
  input logic             cmp_q,
  input logic             rep_q
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_we));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we));

  p_write_follows_read_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_rd, 2));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_status_count_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_out[FLG_PV] == (cnt_out != '0)));

  p_rep_copy_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (done && rep_q && !cmp_q) |-> (cnt_out == '0 && !flags_out[FLG_PV]));

  p_cmp_sub_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (done && cmp_q) |-> flags_out[FLG_N]);

  p_copy_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !cmp_q) |-> (!flags_out[FLG_H] && !flags_out[FLG_N]));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_rd(mem_rd),
  .mem_we(mem_we), .cnt_out(cnt_out), .flags_out(flags_out),
  .cmp_q(cmp_q), .rep_q(rep_q)
);

// File: tb/blk_xfer_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, mode_cmp = 1'b0, mode_dec = 1'b0, mode_rep = 1'b0;
  logic [7:0]  acc_in = '0, flags_in = '0, mem_rdata = '0, mem_wdata, flags_out;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic        mem_rd, mem_we, busy, done;
  logic [15:0] mem_addr, src_ptr, dst_ptr, cnt_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [7:0] mem     [0:255];
  logic [7:0] exp_mem [0:255];

  typedef struct {
    string       tag;
    logic [15:0] src, dst, cnt;
    logic [7:0]  flg;
    int          due;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: synchronous read, one-cycle latency.
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  blk_xfer_seq uut (
    .clk(clk), .rst(rst), .start(start), .mode_cmp(mode_cmp), .mode_dec(mode_dec),
    .mode_rep(mode_rep), .acc_in(acc_in), .src_in(src_in), .dst_in(dst_in),
    .cnt_in(cnt_in), .flags_in(flags_in), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt_out(cnt_out), .flags_out(flags_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: reference model computes the expected result, then starts the op.
  task automatic run_op(input string tag, input bit cmp, input bit dec, input bit rep,
                        input logic [7:0] a, input logic [15:0] s, input logic [15:0] d,
                        input logic [15:0] c, input logic [7:0] f, input bit poke);
    exp_t e;
    logic [15:0] h = s, t = d, b = c;
    logic [7:0]  fl = f, v, df;
    bit go = 1'b1;
    int lat = 0;
    while (go) begin
      v = exp_mem[h[7:0]];
      b = b - 16'd1;
      if (!cmp) begin
        exp_mem[t[7:0]] = v;
        fl[4] = 1'b0;
        fl[1] = 1'b0;
        t = dec ? t - 16'd1 : t + 16'd1;
      end else begin
        df = a - v;
        fl[7] = df[7];
        fl[6] = (df == 8'd0);
        fl[4] = (a[3:0] < v[3:0]);
        fl[1] = 1'b1;
      end
      h = dec ? h - 16'd1 : h + 16'd1;
      fl[2] = (b != 16'd0);
      go = rep && (b != 16'd0) && !(cmp && (a == v));
      lat += go ? 21 : 16;
    end
    @(negedge clk);
    e.tag = tag; e.src = h; e.dst = t; e.cnt = b; e.flg = fl;
    e.due = cyc + 1 + lat;
    sb.push_back(e);
    start = 1'b1; mode_cmp = cmp; mode_dec = dec; mode_rep = rep;
    acc_in = a; src_in = s; dst_in = d; cnt_in = c; flags_in = f;
    @(negedge clk);
    start = 1'b0;
    acc_in = 8'h5A; src_in = 16'h00F0; dst_in = 16'h00E0; cnt_in = 16'h0003;
    flags_in = 8'h00; mode_cmp = ~cmp; mode_dec = ~dec; mode_rep = ~rep;
    if (poke) begin
      // R9: a strobe in the middle of the operation must be ignored.
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops the expected item when done appears.
  initial begin
    exp_t e;
    int bad;
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          chk("R7", "unexpected done", 32'd1, 32'd0);
        end else begin
          e = sb.pop_front();
          chk("R7", {e.tag, " done cycle"}, cyc, e.due);
          chk(e.tag, "src_ptr", src_ptr, e.src);
          chk(e.tag, "dst_ptr", dst_ptr, e.dst);
          chk(e.tag, "cnt_out", cnt_out, e.cnt);
          chk(e.tag, "flags R3 R4", flags_out, e.flg);
          bad = 0;
          for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
          chk(e.tag, "memory image R10", bad, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "reset busy/done", {busy, done}, 32'd0);
    chk("R10", "reset mem strobes", {mem_rd, mem_we}, 32'd0);

    run_op("R1", 1'b0, 1'b0, 1'b0, 8'h00, 16'h0010, 16'h0080, 16'd5, 8'hFF, 1'b0);
    run_op("R1", 1'b0, 1'b1, 1'b0, 8'h00, 16'h0020, 16'h0090, 16'd1, 8'h29, 1'b0);
    run_op("R2", 1'b1, 1'b0, 1'b0, 8'h77, 16'h0030, 16'h0055, 16'd3, 8'h01, 1'b0);
    run_op("R3", 1'b1, 1'b1, 1'b0, exp_mem[8'h40], 16'h0040, 16'h0011, 16'd2, 8'h00, 1'b0);
    run_op("R3", 1'b1, 1'b0, 1'b0, 8'h10, 16'h0001, 16'h0000, 16'd9, 8'hA8, 1'b0);
    run_op("R5", 1'b0, 1'b0, 1'b1, 8'h00, 16'h0010, 16'h00A0, 16'd6, 8'h80, 1'b0);
    run_op("R5", 1'b0, 1'b1, 1'b1, 8'h00, 16'h0050, 16'h00C0, 16'd4, 8'h41, 1'b0);
    run_op("R6", 1'b1, 1'b0, 1'b1, exp_mem[8'h62], 16'h0060, 16'h0000, 16'd10, 8'h00, 1'b0);
    run_op("R6", 1'b1, 1'b1, 1'b1, 8'hFE, 16'h0070, 16'h0000, 16'd5, 8'h01, 1'b0);
    run_op("R8", 1'b0, 1'b0, 1'b0, 8'h00, 16'h0005, 16'h00D0, 16'd0, 8'h00, 1'b0);
    run_op("R9", 1'b1, 1'b0, 1'b0, 8'h33, 16'h0044, 16'h0000, 16'd7, 8'h00, 1'b1);
    run_op("R9", 1'b0, 1'b0, 1'b1, 8'h00, 16'h0018, 16'h00B0, 16'd3, 8'hFF, 1'b1);

    chk("R7", "no pending results", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule